// File: doc/BRIEF.md
# Configurable Feed-Forward Logic Array

This block is a gate array whose structure is set at run time. Three rotor-position bits enter an input column of three pass units. The bits then cross three evolvable columns of eight two-input cells and reach an output column of six taps. The taps drive the six switch-control outputs. Each cell runs one of four Boolean functions on two operands. The operands are picked by a connection vector that can see only the column immediately to its left. Each tap picks exactly one cell of the last evolvable column.

An external search engine writes the netlist one slot at a time into a shadow copy, together with a mask of failed units. A one-cycle load strobe then moves the whole shadow into the active copy, so the outputs never see a half-written netlist. The array between the active registers and the outputs is purely combinational. A failed unit is removed from the netlist: every connection into it and out of it is treated as cleared, and the cells that used it fall back on whatever connections they have left.

Top module: `ffla_array`

## Requirements
- R1: After reset the active netlist is all zero. Every cell and every output then reads 0 whatever `pos_i` is.
- R2: Function codes: 00 is AND, 01 is OR, 10 is NAND, 11 is NOR. Operand A is the lowest-indexed connected source and operand B is the highest-indexed one. Middle connections are not used.
- R3: A cell with exactly one connected source uses it for both operands. A cell with no connected source outputs 0, whatever its function code.
- R4: Sources are strictly feed-forward. The first evolvable column sees only the three input units, on connection bits 0..2. Connection bits 3 and above in that column count as unconnected.
- R5: An output tap drives its selected last-column cell only when its vector has exactly one bit set. Any other vector drives 0.
- R6: Slot and mask writes go to the shadow only and do not change `sw_o`. A `cfg_load_i` pulse copies the whole shadow into the active netlist at that edge. A shadow write made in the same cycle as the load reaches the active netlist only at a later load.
- R7: A failed evolvable cell outputs 0. Its output is removed from every consumer, and a consumer chooses its operands again among its remaining connections.
- R8: A failed input unit removes that sensor bit from every cell in the first evolvable column.
- R9: An output tap whose single selected cell has failed drives 0.
- R10: Slot index `c*8+r` holds column c, row r, with c from 0 to 2. Slots 24..29 hold outputs 0..5, which use only the connection vector; a function code written to them has no effect. Writes to slots 30 and 31 are ignored.
- R11: Fault mask bits 0..2 mark the input units. Bit `3+s` marks the evolvable cell in slot s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pos_i | input | 3 | Rotor-position bits into the input column |
| cfg_we_i | input | 1 | Write one slot of the shadow netlist |
| cfg_sel_i | input | 5 | Slot index for the write |
| cfg_func_i | input | 2 | Function code for the slot |
| cfg_conn_i | input | 8 | Connection vector for the slot |
| flt_we_i | input | 1 | Write the shadow fault mask |
| flt_mask_i | input | 27 | Fault mask, one bit per input unit and evolvable cell |
| cfg_load_i | input | 1 | One-cycle strobe that copies shadow to active |
| sw_o | output | 6 | Switch-control outputs |

## Verification
On every cycle, the assertions check that the active netlist changes only on a load and that it then equals the shadow from before the edge. They also check that a failed cell, an unconnected cell and a tap with a vector that is not one-hot all read 0, and that a tap pointing at a failed cell stays low. Only the bench scenarios can show which operands a cell picks and that the function code table is right. The same holds for the fall-back to the remaining connections after a fault, the ignored upper bits in the first column, and the order of a write against a load made in the same cycle.

// File: rtl/ffla_pkg.sv
package ffla_pkg;

  typedef enum logic [1:0] {
    FN_AND  = 2'b00,
    FN_OR   = 2'b01,
    FN_NAND = 2'b10,
    FN_NOR  = 2'b11
  } fn_e;

  function automatic logic fn_eval(fn_e f, logic a, logic b);
    logic r;
    unique case (f)
      FN_AND:  r = a & b;
      FN_OR:   r = a | b;
      FN_NAND: r = ~(a & b);
      FN_NOR:  r = ~(a | b);
      default: r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/ffla_cfg_store.sv
module ffla_cfg_store #(
  parameter int NUM_EVO   = 24,
  parameter int NUM_SLOTS = 30,
  parameter int CONN_W    = 8,
  parameter int NUM_FLT   = 27,
  parameter int SEL_W     = 5
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                cfg_we_i,
  input  logic [SEL_W-1:0]                    cfg_sel_i,
  input  logic [1:0]                          cfg_func_i,
  input  logic [CONN_W-1:0]                   cfg_conn_i,
  input  logic                                flt_we_i,
  input  logic [NUM_FLT-1:0]                  flt_mask_i,
  input  logic                                load_i,
  output logic [NUM_EVO-1:0][1:0]             func_o,
  output logic [NUM_SLOTS-1:0][CONN_W-1:0]    conn_o,
  output logic [NUM_FLT-1:0]                  flt_o
);

  logic [NUM_EVO-1:0][1:0]          func_sh, func_q;
  logic [NUM_SLOTS-1:0][CONN_W-1:0] conn_sh, conn_q;
  logic [NUM_FLT-1:0]               flt_sh, flt_q;

  logic sel_conn_ok, sel_func_ok;
  assign sel_conn_ok = cfg_we_i && (int'(cfg_sel_i) < NUM_SLOTS);
  assign sel_func_ok = cfg_we_i && (int'(cfg_sel_i) < NUM_EVO);

  // shadow side
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      func_sh <= '0;
      conn_sh <= '0;
      flt_sh  <= '0;
    end else begin
      if (sel_conn_ok) conn_sh[cfg_sel_i] <= cfg_conn_i;
      if (sel_func_ok) func_sh[cfg_sel_i] <= cfg_func_i;
      if (flt_we_i)    flt_sh             <= flt_mask_i;
    end
  end

  // active side: whole netlist swaps on one edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      func_q <= '0;
      conn_q <= '0;
      flt_q  <= '0;
    end else if (load_i) begin
      func_q <= func_sh;
      conn_q <= conn_sh;
      flt_q  <= flt_sh;
    end
  end

  assign func_o = func_q;
  assign conn_o = conn_q;
  assign flt_o  = flt_q;

  p_load_copy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (conn_q == $past(conn_sh)) && (func_q == $past(func_sh)) &&
               (flt_q == $past(flt_sh)));

  p_hold_active_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(conn_q) && $stable(func_q) && $stable(flt_q));

  p_bad_slot_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && (int'(cfg_sel_i) >= NUM_SLOTS)) |=> $stable(conn_sh) && $stable(func_sh));

endmodule

// File: rtl/ffla_cell.sv
module ffla_cell
  import ffla_pkg::*;
#(
  parameter int CONN_W = 8
) (
  input  logic [CONN_W-1:0] src_i,
  input  logic [CONN_W-1:0] conn_i,
  input  fn_e               func_i,
  output logic              y_o
);

  localparam int IDX_W = (CONN_W > 1) ? $clog2(CONN_W) : 1;

  logic [IDX_W-1:0] lo_idx, hi_idx;
  logic             seen;

  // lowest set bit -> operand A, highest -> operand B
  always_comb begin
    lo_idx = '0;
    hi_idx = '0;
    seen   = 1'b0;
    for (int i = 0; i < CONN_W; i++) begin
      if (conn_i[i]) begin
        hi_idx = IDX_W'(i);
        if (!seen) begin
          lo_idx = IDX_W'(i);
          seen   = 1'b1;
        end
      end
    end
  end

  assign y_o = seen ? fn_eval(func_i, src_i[lo_idx], src_i[hi_idx]) : 1'b0;

endmodule

// File: rtl/ffla_tap.sv
module ffla_tap #(
  parameter int CONN_W = 8
) (
  input  logic [CONN_W-1:0] sel_i,
  input  logic [CONN_W-1:0] bad_i,
  input  logic [CONN_W-1:0] src_i,
  output logic              y_o
);

  logic legal;
  assign legal = $onehot(sel_i);
  assign y_o   = legal && |(sel_i & ~bad_i & src_i);

endmodule

// File: rtl/ffla_array.sv
module ffla_array
  import ffla_pkg::*;
#(
  parameter int N_IN  = 3,
  parameter int ROWS  = 8,
  parameter int COLS  = 3,
  parameter int N_OUT = 6,
  localparam int NUM_EVO   = ROWS * COLS,
  localparam int NUM_SLOTS = NUM_EVO + N_OUT,
  localparam int NUM_FLT   = N_IN + NUM_EVO,
  localparam int SEL_W     = $clog2(NUM_SLOTS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_IN-1:0]    pos_i,
  input  logic               cfg_we_i,
  input  logic [SEL_W-1:0]   cfg_sel_i,
  input  logic [1:0]         cfg_func_i,
  input  logic [ROWS-1:0]    cfg_conn_i,
  input  logic               flt_we_i,
  input  logic [NUM_FLT-1:0] flt_mask_i,
  input  logic               cfg_load_i,
  output logic [N_OUT-1:0]   sw_o
);

  logic [NUM_EVO-1:0][1:0]        act_func;
  logic [NUM_SLOTS-1:0][ROWS-1:0] act_conn;
  logic [NUM_FLT-1:0]             act_flt;

  ffla_cfg_store #(
    .NUM_EVO  (NUM_EVO),
    .NUM_SLOTS(NUM_SLOTS),
    .CONN_W   (ROWS),
    .NUM_FLT  (NUM_FLT),
    .SEL_W    (SEL_W)
  ) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cfg_we_i  (cfg_we_i),
    .cfg_sel_i (cfg_sel_i),
    .cfg_func_i(cfg_func_i),
    .cfg_conn_i(cfg_conn_i),
    .flt_we_i  (flt_we_i),
    .flt_mask_i(flt_mask_i),
    .load_i    (cfg_load_i),
    .func_o    (act_func),
    .conn_o    (act_conn),
    .flt_o     (act_flt)
  );

  // level 0 = input column, level c+1 = evolvable column c
  logic [COLS:0][ROWS-1:0] lvl_val;
  logic [COLS:0][ROWS-1:0] lvl_bad;

  // rows past the input count behave as permanently failed sources
  for (genvar r = 0; r < ROWS; r++) begin : g_in
    if (r < N_IN) begin : g_live
      assign lvl_val[0][r] = pos_i[r];
      assign lvl_bad[0][r] = act_flt[r];
    end else begin : g_pad
      assign lvl_val[0][r] = 1'b0;
      assign lvl_bad[0][r] = 1'b1;
    end
  end

  for (genvar c = 0; c < COLS; c++) begin : g_col
    for (genvar r = 0; r < ROWS; r++) begin : g_row
      localparam int SLOT = c * ROWS + r;
      logic            self_bad;
      logic [ROWS-1:0] eff_conn;

      assign self_bad = act_flt[N_IN + SLOT];
      assign eff_conn = self_bad ? '0 : (act_conn[SLOT] & ~lvl_bad[c]);
      assign lvl_bad[c+1][r] = self_bad;

      ffla_cell #(.CONN_W(ROWS)) u_cell (
        .src_i (lvl_val[c]),
        .conn_i(eff_conn),
        .func_i(fn_e'(act_func[SLOT])),
        .y_o   (lvl_val[c+1][r])
      );

      p_failed_cell_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        self_bad |-> !lvl_val[c+1][r]);

      p_unconnected_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (eff_conn == '0) |-> !lvl_val[c+1][r]);
    end
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    ffla_tap #(.CONN_W(ROWS)) u_tap (
      .sel_i(act_conn[NUM_EVO + o]),
      .bad_i(lvl_bad[COLS]),
      .src_i(lvl_val[COLS]),
      .y_o  (sw_o[o])
    );

    p_tap_onehot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($countones(act_conn[NUM_EVO + o]) != 1) |-> !sw_o[o]);

    p_tap_failed_src_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|(act_conn[NUM_EVO + o] & lvl_bad[COLS])) |-> !sw_o[o]);
  end

endmodule

// File: tb/tb_ffla_array.sv
`timescale 1ns/1ps
module tb_ffla_array;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  pos_i = '0;
  logic        cfg_we_i = 1'b0;
  logic [4:0]  cfg_sel_i = '0;
  logic [1:0]  cfg_func_i = '0;
  logic [7:0]  cfg_conn_i = '0;
  logic        flt_we_i = 1'b0;
  logic [26:0] flt_mask_i = '0;
  logic        cfg_load_i = 1'b0;
  logic [5:0]  sw_o;

  ffla_array dut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pos_i     (pos_i),
    .cfg_we_i  (cfg_we_i),
    .cfg_sel_i (cfg_sel_i),
    .cfg_func_i(cfg_func_i),
    .cfg_conn_i(cfg_conn_i),
    .flt_we_i  (flt_we_i),
    .flt_mask_i(flt_mask_i),
    .cfg_load_i(cfg_load_i),
    .sw_o      (sw_o)
  );

  always #5 clk_i = ~clk_i;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [5:0] exp_q[$];
  string      tag_q[$];

  // monitor: compare mid-cycle, well away from the active edge
  always @(negedge clk_i) begin
    if (exp_q.size() > 0) begin
      logic [5:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (sw_o !== e) begin
        errors++;
        $display("FAIL %s pos=%b actual=%b expected=%b", t, pos_i, sw_o, e);
      end
    end
  end

  task automatic cyc();
    @(posedge clk_i);
    #1;
  endtask

  task automatic wr(input int sel, input logic [1:0] fn, input logic [7:0] conn);
    cfg_we_i = 1'b1; cfg_sel_i = 5'(sel); cfg_func_i = fn; cfg_conn_i = conn;
    cyc();
    cfg_we_i = 1'b0;
  endtask

  task automatic wr_with_load(input int sel, input logic [1:0] fn, input logic [7:0] conn);
    cfg_we_i = 1'b1; cfg_sel_i = 5'(sel); cfg_func_i = fn; cfg_conn_i = conn;
    cfg_load_i = 1'b1;
    cyc();
    cfg_we_i = 1'b0; cfg_load_i = 1'b0;
  endtask

  task automatic load();
    cfg_load_i = 1'b1;
    cyc();
    cfg_load_i = 1'b0;
  endtask

  task automatic set_faults(input logic [26:0] m);
    flt_we_i = 1'b1; flt_mask_i = m;
    cyc();
    flt_we_i = 1'b0;
  endtask

  // hand-derived expected switch vectors per scenario
  function automatic logic [5:0] expect_for(int ph, logic [2:0] p);
    logic p0, p1, p2;
    p0 = p[0]; p1 = p[1]; p2 = p[2];
    case (ph)
      1:  return {3'b000, p2, p1, p0};
      2:  return {~(p1 & p2), ~(p0 | p2), p0 & p2, p2, p1, p0};
      3:  return {~p1, ~(p0 | p2), 1'b0, p2, p1, p0};
      4:  return {~p1, p0 | p2, 1'b0, p2, p1, p0};
      5:  return {~p1, p0 | p2, 1'b0, 1'b0, p1, p0};
      6:  return {~p1, p2, 1'b0, 1'b0, p1, p2};
      8:  return {~p1, p0, 1'b0, 1'b0, p1, p0};
      9:  return {~p1, p0, 1'b0, 1'b0, 1'b0, p0};
      10: return {1'b1, p0, 1'b0, 1'b0, 1'b0, p0};
      default: return 6'b0;
    endcase
  endfunction

  task automatic sweep(input int ph, input string tag);
    for (int v = 0; v < 8; v++) begin
      pos_i = 3'(v);
      exp_q.push_back(expect_for(ph, 3'(v)));
      tag_q.push_back(tag);
      cyc();
    end
  endtask

  localparam logic [1:0] F_AND = 2'b00, F_OR = 2'b01, F_NAND = 2'b10, F_NOR = 2'b11;

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    cyc();

    // R1: cleared netlist gives all-zero outputs
    sweep(0, "R1 reset netlist");

    // R6: base pass-through written to shadow only
    for (int r = 0; r < 3; r++) begin
      wr(0 * 8 + r, F_AND, 8'(1 << r));
      wr(1 * 8 + r, F_AND, 8'(1 << r));
      wr(2 * 8 + r, F_AND, 8'(1 << r));
      wr(24 + r, F_AND, 8'(1 << r));
    end
    sweep(0, "R6 shadow not visible");
    load();
    sweep(1, "R6 load applies base");

    // R2: function table and lowest/highest operand pick
    wr(2 * 8 + 3, F_AND,  8'b0000_0111);
    wr(2 * 8 + 4, F_NOR,  8'b0000_0101);
    wr(2 * 8 + 5, F_NAND, 8'b0000_0110);
    wr(24 + 3, F_AND, 8'b0000_1000);
    wr(24 + 4, F_AND, 8'b0001_0000);
    wr(24 + 5, F_AND, 8'b0010_0000);
    load();
    sweep(2, "R2 functions");

    // R3: single source feeds both operands, none gives 0 even for NAND
    wr(2 * 8 + 3, F_NAND, 8'b0000_0000);
    wr(2 * 8 + 5, F_NAND, 8'b0000_0010);
    load();
    sweep(3, "R3 single/none");

    // R6: write in the load cycle waits for the next load
    wr_with_load(2 * 8 + 4, F_OR, 8'b0000_0101);
    sweep(3, "R6 same-cycle write held");
    load();
    sweep(4, "R6 second load");

    // R5, R10: non-one-hot tap, function on an output slot, slots 30 and 31
    wr(24 + 2, F_AND, 8'b0000_0101);
    wr(24 + 1, F_NAND, 8'b0000_0010);
    wr(30, F_NOR, 8'hFF);
    wr(31, F_NOR, 8'hFF);
    load();
    sweep(5, "R5 R10 taps and slots");

    // R4: upper bits of first evolvable column are unconnected
    wr(0, F_AND, 8'b1000_0100);
    load();
    sweep(6, "R4 first column width");

    // R7, R11: fail column 1 row 2 (slot 10, mask bit 13)
    wr(0, F_AND, 8'b0000_0001);
    load();
    sweep(5, "R7 baseline");
    set_faults(27'(1) << 13);
    sweep(5, "R6 fault shadow only");
    load();
    sweep(8, "R7 R11 cell fault reselect");

    // R9: tap points at failed column 2 row 1 (slot 17, mask bit 20)
    set_faults((27'(1) << 13) | (27'(1) << 20));
    load();
    sweep(9, "R9 tap on failed cell");

    // R8: fail input unit 1 (mask bit 1)
    set_faults((27'(1) << 13) | (27'(1) << 20) | 27'(1 << 1));
    load();
    sweep(10, "R8 input fault");

    set_faults('0);
    load();
    sweep(5, "R7 faults cleared");

    cyc();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule